// File: doc/BRIEF.md
# GPIO Pin Resolution and Sense Detect

This block resolves the logic-level state of a bank of general purpose pins, 32 by default. For every pin it takes an 18-bit configuration word, the software output bit, and an external level with a qualifier that says whether anything outside actually drives the pin. From these it works out the following per-pin results:

- the value the input register should read;
- whether the pin's own driver is active and at what level;
- a one-cycle pulse when that driven state changes;
- a flag when the pin's driver fights an external driver.

A single detect line is the OR of the level-sense conditions of all pins.

Drive strength, pull resistors and the input-buffer switch are modelled at the logic level only. All outputs are registered and show the result of the inputs presented one clock earlier. The resolved input bit is kept as state, because a pin that nothing drives keeps its last value. The previous driver enable and driver level are kept as state too, so that changes can be detected.

Top module: `gpio_pin_resolve`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge after it rises, every output is 0.
- R2: Configuration bit 0 is the direction bit (1 = output) and bits 10:8 select the drive mode. The driver is enabled only when the direction bit is 1 and the mode allows the current output bit. Modes 0 to 3 allow both levels, modes 4 and 5 allow only a 1, and modes 6 and 7 allow only a 0. When the driver is enabled, `pin_val_o` equals the output bit.
- R3: Bits 3:2 select the pull: 1 is pull-down (reads 0), 3 is pull-up (reads 1), and 0 and 2 mean no pull. When bit 1 is 1 the input buffer is off. The input then takes the pull value when a pull is set, and otherwise keeps its previous value whatever the external pin does.
- R4: When the input buffer is on and the pin is not externally driven, an enabled driver sets the input to the output bit. With the driver off and a pull set, the pull value sets the input and `pin_val_o`, and `pin_oe_o` reads 1. With neither, the input keeps its previous value.
- R5: When the input buffer is on and the pin is externally driven, the input bit follows the external level.
- R6: `pin_short_o` of a pin is 1 exactly when its input buffer is on, it is externally driven, its driver is enabled and the output bit differs from the external level.
- R7: Bits 17:16 select sense: 2 fires when the external level is 1, 3 fires when it is 0, and 0 and 1 never fire. Sense counts only for pins that are externally driven with the input buffer on. `detect_o` is the OR over all pins.
- R8: `pin_chg_o` of a pin pulses for one cycle exactly when that pin's new `pin_oe_o` or `pin_val_o` differs from its previous registered value.
- R9: Every output reflects the inputs sampled at the previous rising edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_cfg_i | input | NPINS*18 | Configuration words, pin p at bits p*18 and up |
| pin_out_i | input | NPINS | Software output bits |
| ext_level_i | input | NPINS | External pin levels |
| ext_driven_i | input | NPINS | 1 when something outside drives the pin |
| pin_in_o | output | NPINS | Resolved input bits |
| pin_oe_o | output | NPINS | Pin driven by this block (driver or pull) |
| pin_val_o | output | NPINS | Level this block puts on the pin |
| pin_chg_o | output | NPINS | One-cycle change pulse per pin |
| pin_short_o | output | NPINS | Driver fighting an external driver |
| detect_o | output | 1 | OR of all pin sense conditions |

## Verification
The bench first toggles the output bits under every drive mode on different pins. This separates the one-level modes from push-pull, and because each toggle also switches the enable, it shows whether the change pulse reacts to the enable as well as to the level. It then switches off the input buffer with each pull encoding, and afterwards with no pull, while moving the external level. The first step tells a pull that overrides the input from one that is ignored; the second tells holding the input from following the pin. Externally driven patterns with opposing outputs and both sense polarities separate the short flag and the detect OR from the floating-pin path, where pulls stand in for the driver. Long stretches of mixed random configurations then compare every output against a behavioural model on every cycle.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam int CFG_W = 18;

  typedef struct packed {
    logic [1:0] sense;
    logic [2:0] drive;
    logic [1:0] pull;
    logic       ibuf_off;
    logic       dir;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    pin_cfg_t c;
    c.dir      = w[0];
    c.ibuf_off = w[1];
    c.pull     = w[3:2];
    c.drive    = w[10:8];
    c.sense    = w[17:16];
    return c;
  endfunction

  // modes 0-3 both levels, 4-5 only high, 6-7 only low
  function automatic logic drive_allows(input logic [2:0] mode, input logic lvl);
    if (!mode[2]) return 1'b1;
    return mode[1] ? !lvl : lvl;
  endfunction

  // encodings 1 and 3 enable a pull; bit 1 gives its level
  function automatic logic pull_on(input logic [1:0] p);
    return p[0];
  endfunction

  function automatic logic pull_level(input logic [1:0] p);
    return p[1];
  endfunction

  function automatic logic sense_fires(input logic [1:0] s, input logic lvl);
    return s[1] & (s[0] ? !lvl : lvl);
  endfunction
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_res_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_w,
  input  logic             out_bit,
  input  logic             ext_lvl,
  input  logic             ext_drv,
  output logic             in_q,
  output logic             oe_q,
  output logic             val_q,
  output logic             chg_q,
  output logic             short_q,
  output logic             sense_hit
);
  pin_cfg_t c;
  logic oe_raw, oe_n, val_n, in_n, short_n, chg_n;

  assign c = unpack_cfg(cfg_w);

  always_comb begin
    oe_raw    = c.dir & drive_allows(c.drive, out_bit);
    oe_n      = oe_raw;
    val_n     = out_bit;
    in_n      = in_q;
    short_n   = 1'b0;
    sense_hit = 1'b0;
    if (c.ibuf_off) begin
      if (pull_on(c.pull)) in_n = pull_level(c.pull);
    end else if (ext_drv) begin
      in_n      = ext_lvl;
      short_n   = oe_raw & (out_bit != ext_lvl);
      sense_hit = sense_fires(c.sense, ext_lvl);
    end else begin
      if (!oe_raw && pull_on(c.pull)) begin
        oe_n  = 1'b1;
        val_n = pull_level(c.pull);
      end
      if (oe_n) in_n = val_n;
    end
  end

  assign chg_n = (oe_n != oe_q) | (val_n != val_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      oe_q    <= 1'b0;
      val_q   <= 1'b0;
      chg_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      in_q    <= in_n;
      oe_q    <= oe_n;
      val_q   <= val_n;
      chg_q   <= chg_n;
      short_q <= short_n;
    end
  end
endmodule

// File: rtl/gpio_sense_or.sv
module gpio_sense_or #(
  parameter int N = 32
) (
  input  logic [N-1:0] hit,
  output logic         any
);
  always_comb begin
    any = 1'b0;
    for (int i = 0; i < N; i++) any = any | hit[i];
  end
endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS*CFG_W-1:0] pin_cfg_i,
  input  logic [NPINS-1:0]       pin_out_i,
  input  logic [NPINS-1:0]       ext_level_i,
  input  logic [NPINS-1:0]       ext_driven_i,
  output logic [NPINS-1:0]       pin_in_o,
  output logic [NPINS-1:0]       pin_oe_o,
  output logic [NPINS-1:0]       pin_val_o,
  output logic [NPINS-1:0]       pin_chg_o,
  output logic [NPINS-1:0]       pin_short_o,
  output logic                   detect_o
);
  logic [NPINS-1:0] sense_vec;
  logic             sense_any;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_w    (pin_cfg_i[p*CFG_W +: CFG_W]),
      .out_bit  (pin_out_i[p]),
      .ext_lvl  (ext_level_i[p]),
      .ext_drv  (ext_driven_i[p]),
      .in_q     (pin_in_o[p]),
      .oe_q     (pin_oe_o[p]),
      .val_q    (pin_val_o[p]),
      .chg_q    (pin_chg_o[p]),
      .short_q  (pin_short_o[p]),
      .sense_hit(sense_vec[p])
    );
  end

  gpio_sense_or #(.N(NPINS)) u_or (
    .hit(sense_vec),
    .any(sense_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) detect_o <= 1'b0;
    else        detect_o <= sense_any;
  end
endmodule

// File: rtl/gpio_resolve_chk.sv
module gpio_resolve_chk
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPINS*CFG_W-1:0] pin_cfg_i,
  input logic [NPINS-1:0]       pin_out_i,
  input logic [NPINS-1:0]       ext_level_i,
  input logic [NPINS-1:0]       ext_driven_i,
  input logic [NPINS-1:0]       pin_in_o,
  input logic [NPINS-1:0]       pin_oe_o,
  input logic [NPINS-1:0]       pin_val_o,
  input logic [NPINS-1:0]       pin_chg_o,
  input logic [NPINS-1:0]       pin_short_o,
  input logic                   detect_o,
  input logic [NPINS-1:0]       sense_vec
);
  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R3
    ibuf_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cfg_i[i*CFG_W+1] && pin_cfg_i[i*CFG_W+2]) |=>
        (pin_in_o[i] == $past(pin_cfg_i[i*CFG_W+3])));

    // R2
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_cfg_i[i*CFG_W] && pin_cfg_i[i*CFG_W+1]) |=> !pin_oe_o[i]);

    // R6
    short_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_short_o[i] |-> $past(ext_driven_i[i] && pin_cfg_i[i*CFG_W] &&
                               (ext_level_i[i] != pin_out_i[i])));

    // R8
    chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_chg_o[i] |-> ((pin_oe_o[i] != $past(pin_oe_o[i])) ||
                        (pin_val_o[i] != $past(pin_val_o[i]))));

    // R5
    follow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_driven_i[i] && !pin_cfg_i[i*CFG_W+1]) |=>
        (pin_in_o[i] == $past(ext_level_i[i])));
  end

  // R7
  detect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |-> $past(|sense_vec));
endmodule

bind gpio_pin_resolve gpio_resolve_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_cfg_i   (pin_cfg_i),
  .pin_out_i   (pin_out_i),
  .ext_level_i (ext_level_i),
  .ext_driven_i(ext_driven_i),
  .pin_in_o    (pin_in_o),
  .pin_oe_o    (pin_oe_o),
  .pin_val_o   (pin_val_o),
  .pin_chg_o   (pin_chg_o),
  .pin_short_o (pin_short_o),
  .detect_o    (detect_o),
  .sense_vec   (sense_vec)
);

// File: tb/test_gpio_pin_resolve.sv
module test_gpio_pin_resolve;
  localparam int N = 32;
  localparam int W = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [W-1:0]    cfgv [N];
  logic [N*W-1:0]  cfg_flat;
  logic [N-1:0]    outb, lvl, drv;
  logic [N-1:0]    d_in, d_oe, d_val, d_chg, d_short;
  logic            d_det;

  always_comb
    for (int i = 0; i < N; i++) cfg_flat[i*W +: W] = cfgv[i];

  gpio_pin_resolve #(.NPINS(N)) i_gpio_pin_resolve (
    .clk(clk), .rst_n(rst_n), .pin_cfg_i(cfg_flat), .pin_out_i(outb),
    .ext_level_i(lvl), .ext_driven_i(drv), .pin_in_o(d_in), .pin_oe_o(d_oe),
    .pin_val_o(d_val), .pin_chg_o(d_chg), .pin_short_o(d_short), .detect_o(d_det)
  );

  int vecs = 0;
  int bad  = 0;
  logic [N-1:0] e_in, e_oe, e_val, e_chg, e_short;
  logic         e_det;

  function automatic logic [W-1:0] mk(int dir, int off, int pull, int mode, int sns);
    logic [W-1:0] w = '0;
    w[0] = dir[0]; w[1] = off[0]; w[3:2] = pull[1:0];
    w[10:8] = mode[2:0]; w[17:16] = sns[1:0];
    return w;
  endfunction

  // behavioural reference: next expected outputs from current inputs
  task automatic model();
    logic det = 1'b0;
    for (int p = 0; p < N; p++) begin
      int pl, mode, sn;
      bit oe, val, nin, sh;
      case (int'(cfgv[p][3:2])) 1: pl = 0; 3: pl = 1; default: pl = -1; endcase
      mode = int'(cfgv[p][10:8]);
      sn   = int'(cfgv[p][17:16]);
      val  = outb[p];
      if (mode <= 3)      oe = 1;
      else if (mode <= 5) oe = (val == 1);
      else                oe = (val == 0);
      oe  = oe && cfgv[p][0];
      nin = e_in[p];
      sh  = 0;
      if (cfgv[p][1]) begin
        if (pl >= 0) nin = pl[0];
      end else if (drv[p]) begin
        nin = lvl[p];
        sh  = oe && (val != lvl[p]);
        if ((sn == 2 && lvl[p]) || (sn == 3 && !lvl[p])) det = 1'b1;
      end else begin
        if (!oe && pl >= 0) begin oe = 1; val = pl[0]; end
        if (oe) nin = val;
      end
      e_chg[p]   = (oe != e_oe[p]) || (val != e_val[p]);
      e_oe[p]    = oe;
      e_val[p]   = val;
      e_in[p]    = nin;
      e_short[p] = sh;
    end
    e_det = det;
  endtask

  task automatic cmp(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp("R3/R4/R5", "pin_in",  d_in,    e_in);
    cmp("R2/R4",    "pin_oe",  d_oe,    e_oe);
    cmp("R2/R4",    "pin_val", d_val,   e_val);
    cmp("R8",       "pin_chg", d_chg,   e_chg);
    cmp("R6",       "short",   d_short, e_short);
    cmp("R7",       "detect",  {{(N-1){1'b0}}, d_det}, {{(N-1){1'b0}}, e_det});
  endtask

  // R9: inputs set after a falling edge are seen at the next rising edge
  task automatic tick();
    model();
    @(negedge clk);
    check_all();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int p = 0; p < N; p++) cfgv[p] = mk(1, 0, 3, 0, 2);
    outb = '1; lvl = '1; drv = 32'h0000FFFF;
    e_in = '0; e_oe = '0; e_val = '0; e_chg = '0; e_short = '0; e_det = 1'b0;
    // R1: outputs stay zero during reset despite active inputs
    repeat (3) begin @(negedge clk); check_all(); end
    rst_n = 1'b1;
    outb = '0; lvl = '0; drv = '0;
    for (int p = 0; p < N; p++) cfgv[p] = mk(0, 1, 0, 0, 0);
    tick();

    // R2 R8: drive modes per pin, output toggling
    for (int p = 0; p < N; p++) cfgv[p] = mk(1, 1, 0, p % 8, 0);
    for (int k = 0; k < 6; k++) begin outb = (k % 2) ? '1 : '0; tick(); end
    tick();

    // R3: input buffer off with every pull code, external level moving
    for (int p = 0; p < N; p++) cfgv[p] = mk(0, 1, p % 4, 0, 2);
    drv = '1;
    for (int k = 0; k < 4; k++) begin lvl = ~lvl; tick(); end
    // R3: pull removed, input holds
    for (int p = 0; p < N; p++) cfgv[p] = mk(0, 1, 0, 0, 2);
    for (int k = 0; k < 4; k++) begin lvl = ~lvl; tick(); end

    // R5 R6 R7: externally driven, opposing outputs, both sense codes
    for (int p = 0; p < N; p++) cfgv[p] = mk(1, 0, 0, p % 8, p % 4);
    drv = '1;
    for (int k = 0; k < 8; k++) begin
      lvl = 32'hA5A5_0F0F ^ {N{k[0]}}; outb = 32'h3C3C_FF00 ^ {N{k[1]}}; tick();
    end
    // R7: one pin sensing, others quiet
    for (int p = 0; p < N; p++) cfgv[p] = mk(0, 0, 0, 0, 0);
    cfgv[17] = mk(0, 0, 0, 0, 3);
    lvl = '1; tick(); lvl[17] = 1'b0; tick(); lvl[17] = 1'b1; tick();

    // R4: floating pins, pull stands in, then driver takes over
    drv = '0;
    for (int p = 0; p < N; p++) cfgv[p] = mk(0, 0, p % 4, 0, 2);
    tick(); tick();
    for (int p = 0; p < N; p++) cfgv[p] = mk(1, 0, p % 4, p % 8, 2);
    for (int k = 0; k < 4; k++) begin outb = ~outb; tick(); end

    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      if (k % 16 == 0)
        for (int p = 0; p < N; p++)
          cfgv[p] = mk($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 8, $urandom % 4);
      outb = $urandom; lvl = $urandom; drv = $urandom;
      tick();
    end

    summary();
    $finish;
  end
endmodule